// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block drives the control points of a multicycle processor datapath from a small control store, in place of a hand-drawn state machine. A micro-address register selects one 15-bit microinstruction per cycle. The microinstruction's packed fields are expanded into individual datapath strobes and selects. A two-bit sequencing field picks the next micro-address. It can return to the fetch word, jump through an opcode-indexed dispatch table, or step to the following word.

The stored microprogram covers instruction fetch, decode, and one routine each for register-register arithmetic, OR with an immediate, load word, store word and branch-on-equal. Each routine returns to fetch when it finishes. A memory-ready input lets the sequencer wait on slow memory. While a word that touches memory sees memory not ready, the micro-address stays where it is and the write strobes of the program counter and instruction register are withheld. The current micro-address is also brought out as an output.

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the micro-address becomes 0. After that edge the outputs are those of the fetch word.
- R2: The sequencing field works as follows when no memory wait is in force. Code 00 loads micro-address 0. Code 01 loads the dispatch result. Code 10 loads the current micro-address plus 1. The reserved code 11 loads 0.
- R3: Dispatch maps these opcodes to these micro-addresses: 000000 to 4, 000100 to 3, 001101 to 6, 100011 to 8, 101011 to 11.
- R4: Any other opcode dispatches to micro-address 0.
- R5: The fetch word (address 0) drives the following controls, and steps to address 1:
  - `alu_op`=00 (add), `alu_sel_a`=0 (PC), `alu_sel_b`=00 (constant 4).
  - `mem_read`=1 with `mem_addr_sel`=0 (address from PC).
  - `ir_write`=1 and `pc_write`=1 with `pc_src`=0 (ALU result).
- R6: The decode word (address 1) drives the following controls, and dispatches:
  - `alu_op`=00, `alu_sel_a`=0.
  - `alu_sel_b`=10 (shifted sign-extended immediate) with `ext_sign`=1.
- R7: The destination field expands into `reg_write`/`mem_to_reg`/`reg_dst`:
  - 00 gives 0/0/0 (no write).
  - 01 gives 1/0/1 (rd from ALU).
  - 10 gives 1/0/0 (rt from ALU).
  - 11 gives 1/1/0 (rt from memory).
- R8: The second-operand field expands into `alu_sel_b`/`ext_sign`:
  - constant 4 gives 00/0; rt gives 01/0.
  - Shifted sign-extended immediate gives 10/1; sign-extended immediate gives 11/1; zero-extended immediate gives 11/0.
  - The unused code gives 00/0.
  - `alu_op` codes are 00 add, 01 subtract, 10 function field, 11 OR.
- R9: Memory waits behave as follows:
  - The memory field encodes 01 read at PC, 10 read at ALUOut and 11 write at ALUOut.
  - While a word with a non-zero memory field sees `mem_ready` low, the micro-address holds. `mem_read`/`mem_write`/`mem_addr_sel` stay asserted, while `ir_write` and `pc_write` are 0.
  - Memory-touching words are at addresses 0, 9 and 12.
- R10: The branch word (address 3) drives the following controls, then returns to fetch:
  - `alu_op`=01, `alu_sel_a`=1 (rs), `alu_sel_b`=01 (rt).
  - `pc_write_cond`=1 with `pc_src`=1 (ALUOut).
- R11: The routine words drive the following controls:
  - Arithmetic runs 4 then 5: function/rs/rt, then a write of rd.
  - ORI runs 6 then 7: OR/rs/zero-extended immediate, then a write of rt.
  - Load runs 8, 9, 10: add/rs/sign-extended immediate, then a read at ALUOut, then a write of rt from memory.
  - Store runs 11 then 12: the same address add, then a write at ALUOut.
  - Unused addresses drive all controls to 0 and return to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode of the instruction in IR, used by dispatch |
| mem_ready | input | 1 | Memory has completed the current access |
| upc | output | 4 | Current micro-address |
| alu_op | output | 2 | ALU operation select |
| alu_sel_a | output | 1 | First ALU operand: 0 PC, 1 rs |
| alu_sel_b | output | 2 | Second ALU operand select |
| ext_sign | output | 1 | Immediate extension: 1 sign, 0 zero |
| reg_write | output | 1 | Register file write enable |
| mem_to_reg | output | 1 | Register write data from memory |
| reg_dst | output | 1 | Destination register: 1 rd, 0 rt |
| mem_read | output | 1 | Memory read request |
| mem_write | output | 1 | Memory write request |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALUOut |
| ir_write | output | 1 | Instruction register write enable |
| pc_write | output | 1 | Unconditional PC write |
| pc_write_cond | output | 1 | PC write if ALU result is zero |
| pc_src | output | 1 | PC source: 0 ALU, 1 ALUOut |

## Verification
Random opcodes are mixed with all five dispatching codes, and random ready stalls land on each of the three memory words. A design that let the PC or IR strobe fire during a wait would advance the program counter several times per fetch. One that failed to hold the micro-address would skip a memory word or read data that had not arrived. Unknown opcodes and a reset in the middle of a routine are driven on purpose. A wrong dispatch default would wander into a routine instead of back to fetch, and a broken reset would resume from the old micro-address.

// File: rtl/useq_pkg.sv
// Shared types for the microcoded sequencer.
// Assumes a 4-bit micro-address space and a 15-bit encoded microword.
package useq_pkg;
    localparam int UA_W  = 4;
    localparam int OPC_W = 6;

    typedef enum logic [1:0] {
        SQ_FETCH = 2'b00,
        SQ_DISP  = 2'b01,
        SQ_NEXT  = 2'b10,
        SQ_RSVD  = 2'b11
    } seq_e;

    // Encoded microword, MSB first.
    typedef struct packed {
        logic [1:0] alu;    // 00 add, 01 sub, 10 func, 11 or
        logic       src1;   // 0 PC, 1 rs
        logic [2:0] src2;   // 001 four, 010 rt, 011 sx<<2, 100 sx, 111 zx
        logic [1:0] dest;   // 00 none, 01 rd<-ALU, 10 rt<-ALU, 11 rt<-MEM
        logic [1:0] mem;    // 00 none, 01 rd PC, 10 rd ALUOut, 11 wr ALUOut
        logic       irw;    // IR <- memory
        logic [1:0] pcw;    // 00 none, 01 PC<-ALU, 10 cond PC<-ALUOut
        seq_e       seq;
    } uword_t;

    // Builds a microword from its fields.
    function automatic uword_t mkw(input logic [1:0] a, input logic s1,
                                   input logic [2:0] s2, input logic [1:0] d,
                                   input logic [1:0] m, input logic ir,
                                   input logic [1:0] p, input seq_e q);
        uword_t w;
        w.alu = a; w.src1 = s1; w.src2 = s2; w.dest = d;
        w.mem = m; w.irw = ir; w.pcw = p; w.seq = q;
        return w;
    endfunction
endpackage

// File: rtl/useq_ctrl_store.sv
// Control store: read-only microprogram indexed by the micro-address.
// Assumes routine entry points agree with the dispatch table.
module useq_ctrl_store
    import useq_pkg::*;
#(
    parameter int AW = UA_W
) (
    input  logic [AW-1:0] addr,
    output uword_t        word
);
    // Microprogram lookup; unused addresses give an all-zero word (fetch).
    always_comb begin
        case (addr)
            4'd0:    word = mkw(2'b00, 1'b0, 3'b001, 2'b00, 2'b01, 1'b1, 2'b01, SQ_NEXT);
            4'd1:    word = mkw(2'b00, 1'b0, 3'b011, 2'b00, 2'b00, 1'b0, 2'b00, SQ_DISP);
            4'd3:    word = mkw(2'b01, 1'b1, 3'b010, 2'b00, 2'b00, 1'b0, 2'b10, SQ_FETCH);
            4'd4:    word = mkw(2'b10, 1'b1, 3'b010, 2'b00, 2'b00, 1'b0, 2'b00, SQ_NEXT);
            4'd5:    word = mkw(2'b00, 1'b0, 3'b000, 2'b01, 2'b00, 1'b0, 2'b00, SQ_FETCH);
            4'd6:    word = mkw(2'b11, 1'b1, 3'b111, 2'b00, 2'b00, 1'b0, 2'b00, SQ_NEXT);
            4'd7:    word = mkw(2'b00, 1'b0, 3'b000, 2'b10, 2'b00, 1'b0, 2'b00, SQ_FETCH);
            4'd8:    word = mkw(2'b00, 1'b1, 3'b100, 2'b00, 2'b00, 1'b0, 2'b00, SQ_NEXT);
            4'd9:    word = mkw(2'b00, 1'b0, 3'b000, 2'b00, 2'b10, 1'b0, 2'b00, SQ_NEXT);
            4'd10:   word = mkw(2'b00, 1'b0, 3'b000, 2'b11, 2'b00, 1'b0, 2'b00, SQ_FETCH);
            4'd11:   word = mkw(2'b00, 1'b1, 3'b100, 2'b00, 2'b00, 1'b0, 2'b00, SQ_NEXT);
            4'd12:   word = mkw(2'b00, 1'b0, 3'b000, 2'b00, 2'b11, 1'b0, 2'b00, SQ_FETCH);
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/useq_dispatch.sv
// Dispatch table: maps an opcode to the entry micro-address of its routine.
// Assumes unknown opcodes should restart at the fetch word.
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int OW = OPC_W,
    parameter int AW = UA_W
) (
    input  logic [OW-1:0] opcode,
    output logic [AW-1:0] target
);
    localparam logic [OW-1:0] OP_ARITH = OW'(6'b000000);
    localparam logic [OW-1:0] OP_BREQ  = OW'(6'b000100);
    localparam logic [OW-1:0] OP_ORIM  = OW'(6'b001101);
    localparam logic [OW-1:0] OP_LOAD  = OW'(6'b100011);
    localparam logic [OW-1:0] OP_STORE = OW'(6'b101011);

    // Opcode to routine entry lookup.
    always_comb begin
        case (opcode)
            OP_ARITH: target = AW'(4);
            OP_BREQ:  target = AW'(3);
            OP_ORIM:  target = AW'(6);
            OP_LOAD:  target = AW'(8);
            OP_STORE: target = AW'(11);
            default:  target = '0;
        endcase
    end
endmodule

// File: rtl/useq_field_decode.sv
// Field decoder: expands encoded microword fields into datapath controls.
// Assumes a non-zero memory field means the word waits on mem_ready.
module useq_field_decode
    import useq_pkg::*;
(
    input  uword_t     word,
    input  logic       mem_ready,
    output logic       mem_wait,
    output logic [1:0] alu_op,
    output logic       alu_sel_a,
    output logic [1:0] alu_sel_b,
    output logic       ext_sign,
    output logic       reg_write,
    output logic       mem_to_reg,
    output logic       reg_dst,
    output logic       mem_read,
    output logic       mem_write,
    output logic       mem_addr_sel,
    output logic       ir_write,
    output logic       pc_write,
    output logic       pc_write_cond,
    output logic       pc_src
);
    // ALU operation and first operand pass straight through.
    always_comb begin
        alu_op    = word.alu;
        alu_sel_a = word.src1;
    end

    // Second operand select and immediate extension.
    always_comb begin
        case (word.src2)
            3'b001:  {alu_sel_b, ext_sign} = {2'b00, 1'b0};
            3'b010:  {alu_sel_b, ext_sign} = {2'b01, 1'b0};
            3'b011:  {alu_sel_b, ext_sign} = {2'b10, 1'b1};
            3'b100:  {alu_sel_b, ext_sign} = {2'b11, 1'b1};
            3'b111:  {alu_sel_b, ext_sign} = {2'b11, 1'b0};
            default: {alu_sel_b, ext_sign} = 3'b000;
        endcase
    end

    // Register write destination.
    always_comb begin
        case (word.dest)
            2'b01:   {reg_write, mem_to_reg, reg_dst} = 3'b101;
            2'b10:   {reg_write, mem_to_reg, reg_dst} = 3'b100;
            2'b11:   {reg_write, mem_to_reg, reg_dst} = 3'b110;
            default: {reg_write, mem_to_reg, reg_dst} = 3'b000;
        endcase
    end

    // Memory request, address source and wait detection.
    always_comb begin
        mem_read     = (word.mem == 2'b01) || (word.mem == 2'b10);
        mem_write    = (word.mem == 2'b11);
        mem_addr_sel = word.mem[1];
        mem_wait     = (word.mem != 2'b00) && !mem_ready;
    end

    // State-changing strobes, withheld while memory is not ready.
    always_comb begin
        ir_write      = word.irw && !mem_wait;
        pc_write      = (word.pcw == 2'b01) && !mem_wait;
        pc_write_cond = (word.pcw == 2'b10);
        pc_src        = (word.pcw == 2'b10);
    end
endmodule

// File: rtl/useq_top.sv
// Microcoded sequencer top: micro-address register, next-address select,
// control store, dispatch table and field decoder.
// Assumes synchronous active-low reset and a datapath that honours the strobes.
module useq_top
    import useq_pkg::*;
#(
    parameter int OW = OPC_W,
    parameter int AW = UA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [OW-1:0] opcode,
    input  logic          mem_ready,
    output logic [AW-1:0] upc,
    output logic [1:0]    alu_op,
    output logic          alu_sel_a,
    output logic [1:0]    alu_sel_b,
    output logic          ext_sign,
    output logic          reg_write,
    output logic          mem_to_reg,
    output logic          reg_dst,
    output logic          mem_read,
    output logic          mem_write,
    output logic          mem_addr_sel,
    output logic          ir_write,
    output logic          pc_write,
    output logic          pc_write_cond,
    output logic          pc_src
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    uword_t        word;
    logic [AW-1:0] disp_addr;
    logic [AW-1:0] nxt;
    logic          mem_wait;

    useq_ctrl_store #(.AW(AW)) u_store (.addr(upc), .word(word));

    useq_dispatch #(.OW(OW), .AW(AW)) u_disp (.opcode(opcode), .target(disp_addr));

    useq_field_decode u_dec (
        .word(word), .mem_ready(mem_ready), .mem_wait(mem_wait),
        .alu_op(alu_op), .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
        .ext_sign(ext_sign), .reg_write(reg_write), .mem_to_reg(mem_to_reg),
        .reg_dst(reg_dst), .mem_read(mem_read), .mem_write(mem_write),
        .mem_addr_sel(mem_addr_sel), .ir_write(ir_write), .pc_write(pc_write),
        .pc_write_cond(pc_write_cond), .pc_src(pc_src)
    );

    // Next micro-address from the sequencing field.
    always_comb begin
        case (word.seq)
            SQ_DISP: nxt = disp_addr;
            SQ_NEXT: nxt = upc + ONE;
            default: nxt = '0;
        endcase
    end

    // Micro-address register; holds during a memory wait.
    always_ff @(posedge clk) begin
        if (!rst_n)         upc <= '0;
        else if (!mem_wait) upc <= nxt;
    end

    // R2: fetch code returns to address 0
    p_fetch_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (word.seq == SQ_FETCH && !mem_wait) |=> (upc == '0));

    // R2: sequential code steps by one
    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (word.seq == SQ_NEXT && !mem_wait) |=> (upc == $past(upc) + ONE));

    // R3: dispatch lands on the table target
    p_dispatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word.seq == SQ_DISP) |=> (upc == $past(disp_addr)));

    // R9: micro-address holds while memory is busy
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wait) |=> $stable(upc));

    // R9: no PC or IR write during a wait
    p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ready && (mem_read || mem_write)) |-> (!ir_write && !pc_write));

    // R9: read and write never together
    p_mem_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_read, mem_write}));
endmodule

// File: tb/sim_useq_top.sv
module sim_useq_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] opcode;
    logic       mem_ready;
    logic [3:0] upc;
    logic [1:0] alu_op, alu_sel_b;
    logic alu_sel_a, ext_sign, reg_write, mem_to_reg, reg_dst;
    logic mem_read, mem_write, mem_addr_sel, ir_write, pc_write, pc_write_cond, pc_src;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] mu;
    logic [3:0] mn;
    string up_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    useq_top u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .mem_ready(mem_ready), .upc(upc),
        .alu_op(alu_op), .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b), .ext_sign(ext_sign),
        .reg_write(reg_write), .mem_to_reg(mem_to_reg), .reg_dst(reg_dst),
        .mem_read(mem_read), .mem_write(mem_write), .mem_addr_sel(mem_addr_sel),
        .ir_write(ir_write), .pc_write(pc_write), .pc_write_cond(pc_write_cond), .pc_src(pc_src)
    );

    // Order: alu_op(2) sel_a sel_b(2) ext | rw m2r dst | rd wr asel | ir pcw cond src
    function automatic logic [15:0] exp_ctrl(input logic [3:0] a, input logic rdy);
        logic [15:0] v;
        case (a)
            4'd0:  v = {2'b00, 1'b0, 2'b00, 1'b0, 3'b000, 3'b100, rdy, rdy, 2'b00};
            4'd1:  v = {2'b00, 1'b0, 2'b10, 1'b1, 3'b000, 3'b000, 4'b0000};
            4'd3:  v = {2'b01, 1'b1, 2'b01, 1'b0, 3'b000, 3'b000, 4'b0011};
            4'd4:  v = {2'b10, 1'b1, 2'b01, 1'b0, 3'b000, 3'b000, 4'b0000};
            4'd5:  v = {2'b00, 1'b0, 2'b00, 1'b0, 3'b101, 3'b000, 4'b0000};
            4'd6:  v = {2'b11, 1'b1, 2'b11, 1'b0, 3'b000, 3'b000, 4'b0000};
            4'd7:  v = {2'b00, 1'b0, 2'b00, 1'b0, 3'b100, 3'b000, 4'b0000};
            4'd8:  v = {2'b00, 1'b1, 2'b11, 1'b1, 3'b000, 3'b000, 4'b0000};
            4'd9:  v = {2'b00, 1'b0, 2'b00, 1'b0, 3'b000, 3'b101, 4'b0000};
            4'd10: v = {2'b00, 1'b0, 2'b00, 1'b0, 3'b110, 3'b000, 4'b0000};
            4'd11: v = {2'b00, 1'b1, 2'b11, 1'b1, 3'b000, 3'b000, 4'b0000};
            4'd12: v = {2'b00, 1'b0, 2'b00, 1'b0, 3'b000, 3'b011, 4'b0000};
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [3:0] exp_disp(input logic [5:0] op);
        case (op)
            6'b000000: return 4'd4;
            6'b000100: return 4'd3;
            6'b001101: return 4'd6;
            6'b100011: return 4'd8;
            6'b101011: return 4'd11;
            default:   return 4'd0;
        endcase
    endfunction

    function automatic logic [3:0] exp_next(input logic [3:0] a, input logic [5:0] op, input logic rdy);
        if ((a == 4'd0 || a == 4'd9 || a == 4'd12) && !rdy) return a;
        case (a)
            4'd0, 4'd4, 4'd6, 4'd8, 4'd9, 4'd11: return a + 4'd1;
            4'd1: return exp_disp(op);
            default: return 4'd0;
        endcase
    endfunction

    function automatic string ctrl_tag(input logic [3:0] a, input logic rdy);
        if ((a == 4'd0 || a == 4'd9 || a == 4'd12) && !rdy) return "R9";
        case (a)
            4'd0: return "R5";
            4'd1: return "R6";
            4'd3: return "R10";
            4'd5, 4'd7, 4'd10: return "R7";
            4'd4, 4'd6, 4'd8, 4'd11: return "R8";
            4'd9, 4'd12: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (upc model %0d)", tag, got, exp, mu);
        end
    endtask

    function automatic logic [15:0] ctrl_now();
        return {alu_op, alu_sel_a, alu_sel_b, ext_sign, reg_write, mem_to_reg, reg_dst,
                mem_read, mem_write, mem_addr_sel, ir_write, pc_write, pc_write_cond, pc_src};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [5:0] ops [5];
        ops[0] = 6'b000000; ops[1] = 6'b000100; ops[2] = 6'b001101;
        ops[3] = 6'b100011; ops[4] = 6'b101011;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; opcode = 6'h3f; mem_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", {12'd0, upc}, 16'd0);
        chk("R1", ctrl_now(), exp_ctrl(4'd0, 1'b1));
        rst_n = 1'b1;
        mu = 4'd0;
        up_tag = "R1";
        for (int c = 0; c < 4000; c++) begin
            // Directed start: each valid opcode in turn, no stalls; then random.
            if (c < 60) begin
                opcode = ops[(c / 6) % 5];
                mem_ready = 1'b1;
            end else if (c < 90) begin
                opcode = 6'b111111 - 6'(c % 3);   // unknown opcodes, R4
                mem_ready = (c % 4 != 0);
            end else begin
                opcode = ($urandom % 4 == 0) ? 6'($urandom) : ops[$urandom % 5];
                mem_ready = ($urandom % 10) < 7;
                if (c >= 300 && c < 310) mem_ready = 1'b0;  // long stall, R9
            end
            rst_n = (c == 2000) ? 1'b0 : 1'b1;
            #1;
            chk(up_tag, {12'd0, upc}, {12'd0, mu});
            chk(ctrl_tag(mu, mem_ready), ctrl_now(), exp_ctrl(mu, mem_ready));
            if (!rst_n) begin
                mn = 4'd0; up_tag = "R1";
            end else begin
                mn = exp_next(mu, opcode, mem_ready);
                if (mu == 4'd1) up_tag = (exp_disp(opcode) == 4'd0) ? "R4" : "R3";
                else if ((mu == 4'd0 || mu == 4'd9 || mu == 4'd12) && !mem_ready) up_tag = "R9";
                else up_tag = "R2";
            end
            @(posedge clk);
            mu = mn;
            @(negedge clk);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule